// File: doc/BRIEF.md
# Key-Sequence Service Guard

This block sits in front of a watchdog counter and decides which software writes may touch its configuration and when the counter is serviced. Software reaches it through one register write port with 16-bit data. Two of the addresses are key registers and take no data of their own. The unlock key register opens a configuration window. It needs two words in order, 0xC520 and then 0xD928. The window stays open for a fixed number of bus cycles and then closes by itself. The service key register takes 0xA602 and then 0xB480. That pair produces a one-cycle service pulse for the counter. 0xA602 followed by any other word is taken as a deliberate command and produces a one-cycle reset request.

Inside an open window the timeout, window-limit and prescaler registers may be written freely. The control register may be written only once per window. Control bit 4 is the update-allow bit. Once it is cleared, every configuration write is dropped in every later window until the block is reset. The write port is a valid/ready stream with `wr_ready` held high: the block never applies back-pressure, and every beat with `wr_valid` high is consumed in its cycle. The configuration values are plain outputs.

Top module: `svc_key_guard`

## Requirements
- R1: After reset, the control output is 0x0010, the timeout output is 0x0000_4C4B, the window-limit and prescaler outputs are 0, and `cfg_open`, `refresh_pulse` and `reset_req` are low.
- R2: A write of 0xC520 to the unlock address 7, followed by the next unlock write carrying 0xD928, raises `cfg_open` in the cycle after the second write. The configuration writes that follow are then applied to their registers. The addresses are: 1 is the timeout high half, 2 is the timeout low half, 3 is the window-limit high half, 4 is the window-limit low half, and 5 is the prescaler, whose low 3 bits are used.
- R3: The window lasts 256 cycles. A write on the 256th clock edge after the completing unlock write is applied. `cfg_open` is low after that edge, and a write on the 257th edge is dropped.
- R4: A configuration write made while `cfg_open` is low changes no output.
- R5: A wrong first unlock word, or a wrong second word after 0xC520 (0xC520 included), clears the unlock tracker. A following 0xD928 then opens nothing.
- R6: The control register at address 0 takes only the first write of each window. Later control writes in the same window are ignored. A new unlock window allows one write again.
- R7: When control bit 4 is 0, no configuration write is applied, in this window or in any later window, until reset.
- R8: 0xA602 then 0xB480 written to the service address 6 raise `refresh_pulse` in the cycle after the second write.
- R9: 0xA602 followed by any word other than 0xB480 at address 6 raises `reset_req` in the cycle after that word.
- R10: The unlock tracker and the service tracker are separate. Writes to one key address never disturb a half-finished pair at the other.
- R11: `refresh_pulse` and `reset_req` each last exactly one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Always high; the block never stalls a write |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| cfg_open | output | 1 | Configuration window open |
| ctrl_o | output | 16 | Control register; bit 4 is the update-allow bit |
| timeout_o | output | 32 | Timeout value |
| window_o | output | 32 | Window-limit value |
| presc_o | output | 3 | Prescaler select |
| refresh_pulse | output | 1 | One-cycle counter service pulse |
| reset_req | output | 1 | One-cycle reset request |

## Verification
Every result is due one cycle after the clock edge that takes the write that causes it. This holds for register updates, the opening of `cfg_open`, the service pulse and the reset request. The bench drives each beat on a falling edge and reads the outputs on the next falling edge, so each sample lands in that cycle. The window edge is checked by counting exactly 255 idle cycles after the unlock and then writing on the 256th and 257th edges. Pulses go through a scoreboard queue: each expected pulse is pushed when its closing word is driven, and a falling-edge monitor pops one entry for every cycle in which a pulse is high. A stretched, extra or missing pulse therefore shows up as a mismatch or as leftover entries.

// File: rtl/wkg_pkg.sv
package wkg_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int ALLOW_BIT = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 3'd0,
    A_TOUT_HI = 3'd1,
    A_TOUT_LO = 3'd2,
    A_WIN_HI  = 3'd3,
    A_WIN_LO  = 3'd4,
    A_PRESC   = 3'd5,
    A_SERVICE = 3'd6,
    A_UNLOCK  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GOOD = 2'd1,
    SEQ_BAD  = 2'd2
  } seq_res_e;

  localparam logic [DATA_W-1:0] KEY_OPEN_A = 16'hC520;
  localparam logic [DATA_W-1:0] KEY_OPEN_B = 16'hD928;
  localparam logic [DATA_W-1:0] KEY_SVC_A  = 16'hA602;
  localparam logic [DATA_W-1:0] KEY_SVC_B  = 16'hB480;
endpackage

// File: rtl/wkg_key_pair.sv
module wkg_key_pair
  import wkg_pkg::*;
#(
  parameter int              DW     = 16,
  parameter logic [DW-1:0]   FIRST  = '0,
  parameter logic [DW-1:0]   SECOND = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [DW-1:0] data,
  output seq_res_e      res
);
  logic armed_q;

  // Any write to this key address either arms (first word) or consumes the arm.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   armed_q <= 1'b0;
    else if (hit) armed_q <= !armed_q && (data == FIRST);
  end

  always_comb begin
    res = SEQ_IDLE;
    if (hit && armed_q) res = (data == SECOND) ? SEQ_GOOD : SEQ_BAD;
  end
endmodule

// File: rtl/wkg_window.sv
module wkg_window #(
  parameter int CYCLES = 256,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  output logic open
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (open_req)       left_q <= CW'(CYCLES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign open = (left_q != '0);
endmodule

// File: rtl/wkg_cfg_regs.sv
module wkg_cfg_regs
  import wkg_pkg::*;
#(
  parameter int                 DW       = 16,
  parameter int                 PRESC_W  = 3,
  parameter logic [DW-1:0]      CTRL_RST = 16'h0010,
  parameter logic [2*DW-1:0]    TOUT_RST = 32'h0000_4C4B,
  parameter logic [2*DW-1:0]    WIN_RST  = '0,
  localparam int                HALVES   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               open,
  input  logic               new_window,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      ctrl,
  output logic [2*DW-1:0]    timeout,
  output logic [2*DW-1:0]    window,
  output logic [PRESC_W-1:0] presc
);
  localparam logic [HALVES*DW-1:0] RST_CAT = {TOUT_RST, WIN_RST};

  logic              accept;
  logic              ctrl_done_q;
  logic [DW-1:0]     half_q [HALVES];

  assign accept = wr_valid && open && ctrl[ALLOW_BIT];

  // Control: first write of each window only; a new window re-arms it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl        <= CTRL_RST;
      ctrl_done_q <= 1'b0;
    end else if (new_window) begin
      ctrl_done_q <= 1'b0;
    end else if (accept && wr_addr == A_CTRL && !ctrl_done_q) begin
      ctrl        <= wr_data;
      ctrl_done_q <= 1'b1;
    end
  end

  // Half-word value registers at consecutive addresses.
  for (genvar g = 0; g < HALVES; g++) begin : g_half
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(A_TOUT_HI) + ADDR_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        half_q[g] <= RST_CAT[(HALVES-1-g)*DW +: DW];
      else if (accept && wr_addr == MY_ADDR)
        half_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         presc <= '0;
    else if (accept && wr_addr == A_PRESC) presc <= wr_data[PRESC_W-1:0];
  end

  assign timeout = {half_q[0], half_q[1]};
  assign window  = {half_q[2], half_q[3]};
endmodule

// File: rtl/svc_key_guard.sv
module svc_key_guard
  import wkg_pkg::*;
#(
  parameter int                 WIN_CYCLES = 256,
  parameter int                 PRESC_W    = 3,
  parameter logic [15:0]        CTRL_RST   = 16'h0010,
  parameter logic [31:0]        TOUT_RST   = 32'h0000_4C4B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [2:0]         wr_addr,
  input  logic [15:0]        wr_data,
  output logic               cfg_open,
  output logic [15:0]        ctrl_o,
  output logic [31:0]        timeout_o,
  output logic [31:0]        window_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic               refresh_pulse,
  output logic               reset_req
);
  seq_res_e open_res, svc_res;
  logic     open_req;

  assign wr_ready = 1'b1;

  wkg_key_pair #(.DW(DATA_W), .FIRST(KEY_OPEN_A), .SECOND(KEY_OPEN_B)) u_open_key (
    .clk(clk), .rst_n(rst_n),
    .hit(wr_valid && wr_addr == A_UNLOCK),
    .data(wr_data), .res(open_res)
  );

  wkg_key_pair #(.DW(DATA_W), .FIRST(KEY_SVC_A), .SECOND(KEY_SVC_B)) u_svc_key (
    .clk(clk), .rst_n(rst_n),
    .hit(wr_valid && wr_addr == A_SERVICE),
    .data(wr_data), .res(svc_res)
  );

  assign open_req = (open_res == SEQ_GOOD);

  wkg_window #(.CYCLES(WIN_CYCLES)) u_window (
    .clk(clk), .rst_n(rst_n), .open_req(open_req), .open(cfg_open)
  );

  wkg_cfg_regs #(.DW(DATA_W), .PRESC_W(PRESC_W), .CTRL_RST(CTRL_RST),
                 .TOUT_RST(TOUT_RST), .WIN_RST(32'h0)) u_regs (
    .clk(clk), .rst_n(rst_n), .open(cfg_open), .new_window(open_req),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl_o), .timeout(timeout_o), .window(window_o), .presc(presc_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refresh_pulse <= 1'b0;
      reset_req     <= 1'b0;
    end else begin
      refresh_pulse <= (svc_res == SEQ_GOOD);
      reset_req     <= (svc_res == SEQ_BAD);
    end
  end
endmodule

// File: rtl/wkg_checker.sv
module wkg_checker #(
  parameter int PRESC_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic [2:0]         wr_addr,
  input logic [15:0]        wr_data,
  input logic               cfg_open,
  input logic [15:0]        ctrl_o,
  input logic [31:0]        timeout_o,
  input logic [31:0]        window_o,
  input logic [PRESC_W-1:0] presc_o,
  input logic               refresh_pulse,
  input logic               reset_req
);
  // R2: the window only opens right after the closing unlock word
  assert_open_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(wr_valid && wr_addr == 3'd7 && wr_data == 16'hD928));

  // R4: nothing moves while the window is shut
  assert_locked_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(ctrl_o) && $stable(timeout_o) && $stable(window_o) && $stable(presc_o)));

  // R7: update-allow cleared freezes all configuration
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o[4] |=> ($stable(ctrl_o) && $stable(timeout_o) && $stable(window_o) && $stable(presc_o)));

  // R8: a service pulse follows the closing good word
  assert_refresh_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_pulse |-> $past(wr_valid && wr_addr == 3'd6 && wr_data == 16'hB480));

  // R9: a reset request follows a wrong closing word
  assert_reset_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wr_valid && wr_addr == 3'd6 && wr_data != 16'hB480));

  // R11: single-cycle, mutually exclusive pulses
  assert_refresh_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_pulse |=> !refresh_pulse);
  assert_reset_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(refresh_pulse && reset_req));
endmodule

bind svc_key_guard wkg_checker #(.PRESC_W(PRESC_W)) u_wkg_checker (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .cfg_open(cfg_open), .ctrl_o(ctrl_o),
  .timeout_o(timeout_o), .window_o(window_o), .presc_o(presc_o),
  .refresh_pulse(refresh_pulse), .reset_req(reset_req)
);

// File: tb/svc_key_guard_test.sv
`timescale 1ns/1ps
module svc_key_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cfg_open, refresh_pulse, reset_req;
  logic [15:0] ctrl_o;
  logic [31:0] timeout_o, window_o;
  logic [2:0]  presc_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;
  int exp_q[$];   // 1 = refresh pulse, 2 = reset request

  always #4 clk = ~clk;  // 125 MHz

  svc_key_guard uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .cfg_open(cfg_open),
    .ctrl_o(ctrl_o), .timeout_o(timeout_o), .window_o(window_o),
    .presc_o(presc_o), .refresh_pulse(refresh_pulse), .reset_req(reset_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called on a falling edge; the beat is taken on the next rising edge.
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor for the pulse outputs (R8, R9, R11)
  always @(negedge clk) begin
    if (mon_on && (refresh_pulse || reset_req)) begin
      int got;
      got = (refresh_pulse && reset_req) ? 3 : (refresh_pulse ? 1 : 2);
      if (exp_q.size() == 0) chk("R11 unexpected pulse", got, 0);
      else chk("R8/R9 pulse kind", got, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    mon_on = 1'b1;

    // R1 reset state
    chk("R1 ctrl", ctrl_o, 32'h0010);
    chk("R1 timeout", timeout_o, 32'h0000_4C4B);
    chk("R1 window", window_o, 0);
    chk("R1 presc", presc_o, 0);
    chk("R1 flags", {wr_ready, cfg_open, refresh_pulse, reset_req}, 32'h8);

    // R4 locked write dropped
    wr(3'd2, 16'h1111);
    wr(3'd0, 16'h00FF);
    chk("R4 timeout locked", timeout_o, 32'h0000_4C4B);
    chk("R4 ctrl locked", ctrl_o, 32'h0010);

    // R2 unlock and configure
    wr(3'd7, 16'hC520); wr(3'd7, 16'hD928);
    chk("R2 open", cfg_open, 1);
    wr(3'd1, 16'h0001); wr(3'd2, 16'h2345);
    wr(3'd3, 16'h0000); wr(3'd4, 16'h0800); wr(3'd5, 16'h0005);
    chk("R2 timeout", timeout_o, 32'h0001_2345);
    chk("R2 window", window_o, 32'h0000_0800);
    chk("R2 presc", presc_o, 5);

    // R6 control written once per window
    wr(3'd0, 16'h0013);
    chk("R6 first ctrl", ctrl_o, 32'h0013);
    wr(3'd0, 16'h0031);
    chk("R6 second ctrl ignored", ctrl_o, 32'h0013);

    // R3 window boundary: unlock completes on edge k
    wr(3'd7, 16'hC520); wr(3'd7, 16'hD928);
    idle(255);
    chk("R3 open before last edge", cfg_open, 1);
    wr(3'd2, 16'hAAAA);   // edge k+256
    chk("R3 last edge accepted", timeout_o, 32'h0001_AAAA);
    chk("R3 closed", cfg_open, 0);
    wr(3'd2, 16'h5555);   // edge k+257
    chk("R3 after close dropped", timeout_o, 32'h0001_AAAA);

    // R5 broken unlock pairs
    wr(3'd7, 16'hC520); wr(3'd7, 16'h1234); wr(3'd7, 16'hD928);
    chk("R5 wrong second", cfg_open, 0);
    wr(3'd7, 16'hC520); wr(3'd7, 16'hC520); wr(3'd7, 16'hD928);
    chk("R5 repeated first", cfg_open, 0);
    wr(3'd7, 16'h0000); wr(3'd7, 16'hD928);
    chk("R5 wrong first", cfg_open, 0);
    wr(3'd2, 16'h0101);
    chk("R5 still locked", timeout_o, 32'h0001_AAAA);

    // R6 new window allows control again
    wr(3'd7, 16'hC520); wr(3'd7, 16'hD928);
    wr(3'd0, 16'h0017);
    chk("R6 new window ctrl", ctrl_o, 32'h0017);

    // R8 good service pair
    wr(3'd6, 16'hA602);
    exp_q.push_back(1);
    wr(3'd6, 16'hB480);
    idle(2);
    // R9 broken service pair; lone non-key word produces nothing
    wr(3'd6, 16'hA602);
    exp_q.push_back(2);
    wr(3'd6, 16'h0000);
    idle(2);
    wr(3'd6, 16'h1234);
    idle(2);
    chk("R8 R9 scoreboard drained", exp_q.size(), 0);

    // R10 interleaved pairs at both key addresses
    idle(300);
    chk("R10 window closed first", cfg_open, 0);
    wr(3'd7, 16'hC520);
    wr(3'd6, 16'hA602);
    exp_q.push_back(1);
    wr(3'd6, 16'hB480);
    wr(3'd7, 16'hD928);
    chk("R10 unlock survives service writes", cfg_open, 1);
    idle(2);
    chk("R10 service survives unlock writes", exp_q.size(), 0);

    // R7 clearing update-allow freezes configuration
    wr(3'd0, 16'h0007);
    chk("R7 ctrl allow cleared", ctrl_o, 32'h0007);
    wr(3'd2, 16'h7777);
    chk("R7 same window dropped", timeout_o, 32'h0001_AAAA);
    wr(3'd7, 16'hC520); wr(3'd7, 16'hD928);
    wr(3'd1, 16'h9999); wr(3'd0, 16'h0010); wr(3'd5, 16'h0002);
    chk("R7 later window timeout", timeout_o, 32'h0001_AAAA);
    chk("R7 later window ctrl", ctrl_o, 32'h0007);
    chk("R7 later window presc", presc_o, 5);

    idle(3);
    chk("R11 no stray pulses pending", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule